// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator with Indirect Configuration

This block collects a wide vector of interrupt request lines, latches the ones that fire, and reports them upward through a summary tree to a single host interrupt line. Inputs are grouped eight to a block. Blocks are grouped eight to a group. A root byte flags the groups that hold pending work. Software walks the tree: it reads the root, then the status byte of a flagged group, then selects a flagged block and reads that block's pending byte.

All access goes through a byte-wide register window at a parameterised base address. The window has nine byte locations. Each input is configured through one shared configuration byte, which acts on the block named by a block-select register. That byte chooses edge or level detection, masks each polarity independently, and clears the input's pending latch. A write to it takes effect only when its top bit is set. A live-level byte shows the synchronized state of the eight inputs in the selected block. The serial link that carries the register accesses lies outside this block.

Top module: `irq_tree_ctrl`

## Requirements
- R1: After reset every input is in edge mode with both polarity masks set and no pending latch. The block select is 0, the root reads 0 and `host_irq` is low.
- R2: A write at offset +5 loads the block select, which reads back at +5. Writes to the read-only offsets (+0..+4, +6, +8) have no effect. Writes to addresses outside the window (below base or above base+8) also have no effect.
- R3: A write at offset +7 acts only when data bit 7 is 1. Data bits 6:4 name input sel*8+idx, and that input is the only one affected.
- R4: In edge mode (config bit 0 = 0), a 0-to-1 transition latches when bit 2 is clear, and a 1-to-0 transition latches when bit 1 is clear. Both directions can be enabled together.
- R5: In level mode (config bit 0 = 1), a high input latches when bit 2 is clear and a low input latches when bit 1 is clear. The input re-latches for as long as that level persists.
- R6: With bits 1 and 2 both set, no new event latches and the input's latch is hidden from every status byte. Clearing a mask makes a held latch visible again.
- R7: A config write with bit 3 set clears the named input's latch. A detection in the same cycle as the clear wins, so the latch stays set.
- R8: The byte at +6 has bit i set when input sel*8+i is latched and not fully masked.
- R9: The byte at +1+m has bit i set when block m*8+i has any visible pending bit. Root bit m+1 is set when group m's byte is non-zero. Root bit 0 always reads 0.
- R10: `host_irq` is high exactly when any root bit is set.
- R11: The byte at +8 returns the synchronized, unlatched level of the eight inputs of the selected block. Offset +7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_src | input | NUM_BLOCKS*8 | Asynchronous interrupt request lines |
| bus_wen | input | 1 | Write strobe for one byte |
| bus_addr | input | 16 | Byte address, for both reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| host_irq | output | 1 | Summary interrupt to the host |

## Verification
The bench builds the block with its defaults: 32 blocks, four groups and a window base of 0x01B0. This fills every group status byte and every root bit from 1 to 4. As a result, the full fan-in of the summary tree and both ends of the index range are exercised. Directed sequences cover each detection mode, the masked-but-latched case, clears that race a persistent level, and writes that lack the enable bit. Seeded random rounds then mix configuration writes with input toggles, and after each round every block's pending and live bytes are compared.

// File: rtl/irqt_pkg.sv
// Package: window offsets and config-byte field positions shared by the
// aggregator modules. The offsets and bit positions are behaviour that
// software decodes, so they are fixed here and never parameterised.
package irqt_pkg;
    localparam logic [15:0] OFF_ROOT = 16'd0;
    localparam logic [15:0] OFF_GRP0 = 16'd1;
    localparam logic [15:0] OFF_SEL  = 16'd5;
    localparam logic [15:0] OFF_PEND = 16'd6;
    localparam logic [15:0] OFF_CFG  = 16'd7;
    localparam logic [15:0] OFF_LIVE = 16'd8;
    localparam logic [15:0] OFF_LAST = 16'd8;

    localparam int CFG_LVL = 0;   // 1 = level detect
    localparam int CFG_MLO = 1;   // mask falling / low
    localparam int CFG_MHI = 2;   // mask rising / high
    localparam int CFG_CLR = 3;   // clear latch
    localparam int CFG_IDX = 4;   // lsb of 3-bit index
    localparam int CFG_WEN = 7;   // write enable
endpackage

// File: rtl/irqt_sync.sv
// Module: irqt_sync
// Two-flop synchronizer for a vector of asynchronous request lines.
// Assumes each line is held long enough to be sampled by two edges.
module irqt_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two-stage capture of the raw lines into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/irqt_cell.sv
// Module: irqt_cell
// One interrupt input: holds its mode/mask bits, detects edges or levels on
// the synchronized line, and keeps a sticky pending latch. Assumes cfg_we is
// asserted for one cycle per accepted config write naming this input.
module irqt_cell
    import irqt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_s,
    input  logic       cfg_we,
    input  logic [3:0] cfg_bits,
    output logic       pend_vis
);
    logic line_d, mode_lvl, mask_lo, mask_hi, latch, evt, clr;

    // Delayed copy of the synchronized line for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) line_d <= 1'b0;
        else        line_d <= line_s;
    end

    // Detection condition for the current mode and masks.
    always_comb begin
        if (mode_lvl)
            evt = (line_s & ~mask_hi) | (~line_s & ~mask_lo);
        else
            evt = (line_s & ~line_d & ~mask_hi) | (~line_s & line_d & ~mask_lo);
        clr = cfg_we & cfg_bits[CFG_CLR];
    end

    // Mode and mask storage, loaded by an accepted config write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_lvl <= 1'b0;
            mask_lo  <= 1'b1;
            mask_hi  <= 1'b1;
        end else if (cfg_we) begin
            mode_lvl <= cfg_bits[CFG_LVL];
            mask_lo  <= cfg_bits[CFG_MLO];
            mask_hi  <= cfg_bits[CFG_MHI];
        end
    end

    // Sticky latch: a new event takes priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) latch <= 1'b0;
        else        latch <= evt | (latch & ~clr);
    end

    assign pend_vis = latch & ~(mask_lo & mask_hi);

    // R7
    evt_sets_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> latch);
    // R7
    clr_drops_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt) |=> !latch);
    // R6
    masked_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_lo && mask_hi && !latch && !cfg_we) |=> !latch);
endmodule

// File: rtl/irqt_regs.sv
// Module: irqt_regs
// Register window decode, block select, config write steering, and the
// group/root summary tree. Assumes NUM_BLOCKS is a power of two of at most
// 32, so that the four group bytes in the window cover every block.
module irqt_regs
    import irqt_pkg::*;
#(
    parameter int          NUM_BLOCKS = 32,
    parameter logic [15:0] BASE_ADDR  = 16'h01B0,
    localparam int         NUM_IRQ    = NUM_BLOCKS * 8,
    localparam int         SEL_W      = $clog2(NUM_BLOCKS),
    localparam int         NUM_GRP    = (NUM_BLOCKS + 7) / 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wen,
    input  logic [15:0]        bus_addr,
    input  logic [7:0]         bus_wdata,
    input  logic [NUM_IRQ-1:0] pend_vis,
    input  logic [NUM_IRQ-1:0] line_s,
    output logic [7:0]         bus_rdata,
    output logic [NUM_IRQ-1:0] cfg_we,
    output logic [3:0]         cfg_bits,
    output logic               host_irq
);
    localparam int IDX_W = SEL_W + 3;

    logic [15:0]      off;
    logic             in_win, wr_cfg;
    logic [SEL_W-1:0] blk_sel;
    logic [IDX_W-1:0] cfg_idx;
    logic [7:0]       grp [NUM_GRP];
    logic [7:0]       root;

    // Window hit and offset of the current address.
    always_comb begin
        off    = bus_addr - BASE_ADDR;
        in_win = (bus_addr >= BASE_ADDR) && (off <= OFF_LAST);
        wr_cfg = bus_wen && in_win && (off == OFF_CFG) && bus_wdata[CFG_WEN];
    end

    // Block select register.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   blk_sel <= '0;
        else if (bus_wen && in_win && off == OFF_SEL) blk_sel <= bus_wdata[SEL_W-1:0];
    end

    assign cfg_idx  = {blk_sel, bus_wdata[CFG_IDX +: 3]};
    assign cfg_bits = bus_wdata[3:0];

    // One write strobe per input, decoded from select and sub-index.
    for (genvar k = 0; k < NUM_IRQ; k++) begin : g_we
        assign cfg_we[k] = wr_cfg && (cfg_idx == IDX_W'(k));
    end

    // Group bytes and root byte from visible pending bits.
    always_comb begin
        root = '0;
        for (int m = 0; m < NUM_GRP; m++) begin
            for (int i = 0; i < 8; i++) begin
                grp[m][i] = 1'b0;
                if (m * 8 + i < NUM_BLOCKS)
                    grp[m][i] = |pend_vis[(m * 8 + i) * 8 +: 8];
            end
            root[m + 1] = |grp[m];
        end
    end

    assign host_irq = |root;

    // Read multiplexer over the window.
    always_comb begin
        bus_rdata = '0;
        if (in_win) begin
            case (off)
                OFF_ROOT: bus_rdata = root;
                OFF_SEL:  bus_rdata = 8'(blk_sel);
                OFF_PEND: bus_rdata = pend_vis[{blk_sel, 3'b000} +: 8];
                OFF_LIVE: bus_rdata = line_s[{blk_sel, 3'b000} +: 8];
                default: begin
                    for (int m = 0; m < NUM_GRP; m++)
                        if (off == OFF_GRP0 + 16'(m)) bus_rdata = grp[m];
                end
            endcase
        end
    end

    // R2
    sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == BASE_ADDR + OFF_SEL) |=> blk_sel == $past(bus_wdata[SEL_W-1:0]));
    // R3
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cfg_we));
    // R3
    no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == BASE_ADDR + OFF_CFG && !bus_wdata[CFG_WEN]) |-> cfg_we == '0);
endmodule

// File: rtl/irq_tree_ctrl.sv
// Module: irq_tree_ctrl
// Top of the interrupt aggregator: synchronizes the request lines, runs
// one detection cell per line, and exposes the register window and the
// summary output. Assumes register accesses are byte-wide and single-cycle.
module irq_tree_ctrl #(
    parameter int          NUM_BLOCKS = 32,
    parameter logic [15:0] BASE_ADDR  = 16'h01B0,
    localparam int         NUM_IRQ    = NUM_BLOCKS * 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_src,
    input  logic               bus_wen,
    input  logic [15:0]        bus_addr,
    input  logic [7:0]         bus_wdata,
    output logic [7:0]         bus_rdata,
    output logic               host_irq
);
    logic [NUM_IRQ-1:0] line_s, pend_vis, cfg_we;
    logic [3:0]         cfg_bits;

    irqt_sync #(.W(NUM_IRQ)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(irq_src), .q(line_s)
    );

    for (genvar k = 0; k < NUM_IRQ; k++) begin : g_cell
        irqt_cell u_cell (
            .clk(clk), .rst_n(rst_n), .line_s(line_s[k]),
            .cfg_we(cfg_we[k]), .cfg_bits(cfg_bits), .pend_vis(pend_vis[k])
        );
    end

    irqt_regs #(.NUM_BLOCKS(NUM_BLOCKS), .BASE_ADDR(BASE_ADDR)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .pend_vis(pend_vis), .line_s(line_s),
        .bus_rdata(bus_rdata), .cfg_we(cfg_we), .cfg_bits(cfg_bits),
        .host_irq(host_irq)
    );

    // R10
    host_tree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq == (|pend_vis));
endmodule

// File: tb/irq_tree_ctrl_tb.sv
`timescale 1ns/1ps
module irq_tree_ctrl_tb;
    localparam int          NB   = 32;
    localparam int          NI   = NB * 8;
    localparam logic [15:0] BASE = 16'h01B0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NI-1:0] irq_src = '0;
    logic          bus_wen = 1'b0;
    logic [15:0]   bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          host_irq;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    bit m_lvl [NI], m_mlo [NI], m_mhi [NI], m_lat [NI];

    always #2 clk = ~clk;

    irq_tree_ctrl #(.NUM_BLOCKS(NB), .BASE_ADDR(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_wen(bus_wen),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .host_irq(host_irq)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic bit lvl_act(int k);
        return m_lvl[k] && ((irq_src[k] && !m_mhi[k]) || (!irq_src[k] && !m_mlo[k]));
    endfunction

    function automatic bit vis(int k);
        return m_lat[k] && !(m_mlo[k] && m_mhi[k]);
    endfunction

    function automatic logic [7:0] exp_pend(int b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = vis(b * 8 + i);
        return r;
    endfunction

    function automatic logic [7:0] exp_grp(int m);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = |exp_pend(m * 8 + i);
        return r;
    endfunction

    function automatic logic [7:0] exp_root();
        logic [7:0] r = '0;
        for (int m = 0; m < NB / 8; m++) r[m + 1] = |exp_grp(m);
        return r;
    endfunction

    // Select the block of input k and write a config byte; update the model.
    task automatic cfg(input int k, input logic [7:0] raw);
        logic [7:0] d;
        d = raw;
        d[6:4] = 3'(k % 8);
        wr(BASE + 16'd5, 8'(k / 8));
        wr(BASE + 16'd7, d);
        if (d[7]) begin
            if (d[3]) m_lat[k] = 0;
            if (lvl_act(k)) m_lat[k] = 1;
            m_lvl[k] = d[0]; m_mlo[k] = d[1]; m_mhi[k] = d[2];
            if (lvl_act(k)) m_lat[k] = 1;
        end
        repeat (2) @(negedge clk);
    endtask

    // Drive new input levels and update the model once they settle.
    task automatic drive(input logic [NI-1:0] nv);
        logic [NI-1:0] ov;
        @(negedge clk);
        ov = irq_src;
        irq_src = nv;
        for (int k = 0; k < NI; k++) begin
            if (!m_lvl[k] && ov[k] != nv[k]) begin
                if (nv[k] && !m_mhi[k]) m_lat[k] = 1;
                if (!nv[k] && !m_mlo[k]) m_lat[k] = 1;
            end
            if (lvl_act(k)) m_lat[k] = 1;
        end
        repeat (5) @(negedge clk);
    endtask

    task automatic set1(input int k, input logic v);
        logic [NI-1:0] nv;
        nv = irq_src;
        nv[k] = v;
        drive(nv);
    endtask

    task automatic check_blk(input string tag, input int b);
        logic [7:0] d;
        wr(BASE + 16'd5, 8'(b));
        rd(BASE + 16'd6, d);
        chk(tag, d, exp_pend(b));
    endtask

    task automatic check_all();
        logic [7:0] d;
        for (int b = 0; b < NB; b++) begin
            wr(BASE + 16'd5, 8'(b));
            rd(BASE + 16'd6, d);
            chk("R8 block pending", d, exp_pend(b));
            rd(BASE + 16'd8, d);
            chk("R11 live level", d, irq_src[b * 8 +: 8]);
        end
        for (int m = 0; m < NB / 8; m++) begin
            rd(BASE + 16'(1 + m), d);
            chk("R9 group byte", d, exp_grp(m));
        end
        rd(BASE, d);
        chk("R9 root byte", d, exp_root());
        chk("R10 host_irq", {7'd0, host_irq}, {7'd0, |exp_root()});
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog got=hung exp=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd20240611));
        for (int k = 0; k < NI; k++) begin
            m_lvl[k] = 0; m_mlo[k] = 1; m_mhi[k] = 1; m_lat[k] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        rd(BASE, d);         chk("R1 root after reset", d, 8'h00);
        rd(BASE + 16'd5, d); chk("R1 select after reset", d, 8'h00);
        chk("R1 host_irq after reset", {7'd0, host_irq}, 8'h00);
        set1(9, 1'b1);
        check_blk("R1 masked at reset", 1);
        set1(9, 1'b0);
        check_all();

        // R2 select register and ignored writes
        wr(BASE + 16'd5, 8'd5);
        rd(BASE + 16'd5, d); chk("R2 select readback", d, 8'd5);
        wr(BASE + 16'd9, 8'h11);
        wr(BASE - 16'd1, 8'h12);
        wr(BASE + 16'h0105, 8'h13);
        wr(BASE, 8'h14);
        wr(BASE + 16'd6, 8'hFF);
        rd(BASE + 16'd5, d); chk("R2 select unchanged", d, 8'd5);
        rd(BASE, d);         chk("R2 root unchanged", d, 8'h00);
        rd(BASE + 16'd7, d); chk("R11 config reads zero", d, 8'h00);

        // R3 enable bit required; index picks one input
        cfg(3, 8'h0B);
        set1(3, 1'b1);
        check_blk("R3 write without enable ignored", 0);
        cfg(3, 8'h82);
        set1(3, 1'b0);
        set1(3, 1'b1);
        check_blk("R3 only indexed input latches", 0);
        chk("R3 expected bit 3", exp_pend(0), 8'h08);

        // R7 clear
        cfg(3, 8'h8A);
        check_blk("R7 clear drops latch", 0);

        // R4 falling only, then both edges
        cfg(10, 8'h84);
        set1(10, 1'b1);
        check_blk("R4 rising masked", 1);
        set1(10, 1'b0);
        check_blk("R4 falling latches", 1);
        cfg(11, 8'h80);
        set1(11, 1'b1);
        check_blk("R4 both edges rising", 1);
        cfg(11, 8'h88);
        set1(11, 1'b0);
        check_blk("R4 both edges falling", 1);

        // R5 level modes; clear racing a held level
        cfg(20, 8'h83);
        set1(20, 1'b1);
        check_blk("R5 active high latches", 2);
        cfg(20, 8'h8B);
        check_blk("R7 event wins over clear", 2);
        set1(20, 1'b0);
        cfg(20, 8'h8B);
        check_blk("R5 clear after level gone", 2);
        cfg(21, 8'h85);
        check_blk("R5 active low latches", 2);

        // R6 full mask hides, unmask reveals
        cfg(21, 8'h87);
        check_blk("R6 fully masked hidden", 2);
        cfg(21, 8'h85);
        check_blk("R6 unmask reveals latch", 2);

        // R9 top group
        cfg(247, 8'h82);
        set1(247, 1'b1);
        rd(BASE + 16'd4, d); chk("R9 last group byte", d, exp_grp(3));
        rd(BASE, d);         chk("R9 root top bit", d, exp_root());
        check_all();

        // Random rounds
        for (int r = 0; r < 25; r++) begin
            for (int j = 0; j < 4; j++) begin
                int k;
                logic [7:0] b;
                k = int'($urandom_range(NI - 1));
                b = 8'($urandom);
                b[7] = ($urandom_range(9) < 8);
                cfg(k, b);
            end
            begin
                logic [NI-1:0] nv;
                nv = irq_src;
                for (int j = 0; j < 10; j++) begin
                    int k;
                    k = int'($urandom_range(NI - 1));
                    nv[k] = ~nv[k];
                end
                drive(nv);
            end
            check_all();
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule